// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits beside a small CPU core and decides which interrupt the core should take next. It watches fourteen maskable request slots and an unmaskable software trap. It qualifies each slot with its own enable bit and with a parameter that marks the slot as wired or unused. It then offers the winner to the core through a take-request line. On the core's acknowledge pulse, the block freezes the winner's source code and its 16-bit vector address. The vector address is computed from the slot position, so no table is stored.

A global mask bit blocks every maskable slot. The bit is set by reset and on every accepted entry. Before an entry sets it, its previous value is copied into a one-deep shadow. A return pulse from the core copies the shadow back into the mask. The shadow clears on reset, so the return from the reset handler opens the mask.

A separate wake-up output tells the power controller that an enabled request may end a low-power state. In full halt, only the four external-interrupt slots can wake the core. In active-halt, the clock/time-base slot can wake it as well. The trap and the peripheral slots never wake the core.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, the next edge sets `gmask` to 1, `vec_addr` to 16'hFFFE and `src_idx` to 0 (the reset code). This happens whatever requests are present.
- R2: The trap outranks every slot. Among qualified slots, the lowest slot number wins.
- R3: Source codes are: reset 0, trap 1, slot n is n+2. The latched `vec_addr` equals 16'hFFFE minus twice the source code, so slot 13 gives 16'hFFE0.
- R4: Slots 0, 6, 12 and 13 are unused. They never raise `entry_req` and never appear in `src_idx`.
- R5: While `gmask` is 1, slot requests do not raise `entry_req`. A trap request raises it regardless of `gmask`.
- R6: On an edge with `entry_ack` and `entry_req` both high, the block latches the winner into `src_idx` and `vec_addr`, sets `gmask`, and copies the old `gmask` into the shadow. The outputs then hold until the next such edge, whatever the requests do.
- R7: A `ret_pulse` edge without an accepted entry loads `gmask` from the shadow. The shadow resets to 0. An accepted entry on the same edge wins over the return.
- R8: An `entry_ack` while `entry_req` is low changes none of `gmask`, `vec_addr` and `src_idx`.
- R9: With `pwr_mode` = 2'b01 (halt), `wake` is high exactly when one of slots 2 to 5 is both requested and enabled. `gmask` has no effect on this.
- R10: With `pwr_mode` = 2'b10 (active-halt), `wake` is high exactly when one of slots 1 to 5 is both requested and enabled.
- R11: With `pwr_mode` = 2'b00 or 2'b11 (run), `wake` is low. The trap and slots 7 to 11 never drive `wake`.
- R12: A slot whose `slot_en` bit is 0 is ignored for arbitration and wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; doubles as the reset source |
| slot_req | input | 14 | Request level per slot, bit n is slot n |
| slot_en | input | 14 | Enable per slot |
| trap_req | input | 1 | Software trap request, never masked |
| entry_ack | input | 1 | Core accepts the offered interrupt (one-cycle pulse) |
| ret_pulse | input | 1 | Core finished a handler (one-cycle pulse) |
| pwr_mode | input | 2 | 00 run, 01 halt, 10 active-halt, 11 run |
| entry_req | output | 1 | A qualified source is waiting for the core |
| vec_addr | output | 16 | Latched vector address of the accepted source |
| src_idx | output | 4 | Latched source code of the accepted source |
| gmask | output | 1 | Global mask bit |
| wake | output | 1 | Request to leave the current low-power state |

## Verification
A corrupted mask bit shows on `entry_req` in the same cycle: a slot request is either let through while masked, or refused while open. A wrong shadow value shows only later, at the first `ret_pulse` edge after the entry. From then on the mask comes back wrong, so the bench places a return after every entry and compares `gmask` one edge later. A bad priority scan or code-to-address step shows on the edge that accepts the entry. That is why single-slot, pair and mixed patterns are all acknowledged and compared one edge later.

// File: rtl/irqv_pkg.sv
// Package: shared encodings for the interrupt vector controller.
// Assumes: source codes count from the top of the vector area downward.
package irqv_pkg;

    // Power-mode encoding presented by the power controller
    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_HALT  = 2'b01,
        PM_AHALT = 2'b10,
        PM_RSVD  = 2'b11
    } pmode_e;

    // Fixed source codes ahead of the slot range
    localparam int unsigned CODE_RESET = 0;
    localparam int unsigned CODE_TRAP  = 1;
    localparam int unsigned SLOT_BASE  = 2;

endpackage

// File: rtl/irqv_arbiter.sv
// Module: fixed-priority arbiter over trap and maskable slots.
// What it does: qualifies each slot by request, enable, wiring and mask,
// then reports whether any source waits and the code of the winner.
// Assumes: lower slot number means higher priority; trap beats all slots.
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int unsigned       NUM_SLOTS  = 14,
    parameter int unsigned       CODE_W     = 4,
    parameter logic [NUM_SLOTS-1:0] USED_SLOTS = 14'h0FBE
) (
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic [NUM_SLOTS-1:0] slot_en,
    input  logic                 trap_req,
    input  logic                 gmask,
    output logic                 any_win,
    output logic [CODE_W-1:0]    win_code
);

    logic [NUM_SLOTS-1:0] qual;

    // Per-slot qualification: wired, requested, enabled and not masked
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_qual
        assign qual[g] = USED_SLOTS[g] & slot_req[g] & slot_en[g] & ~gmask;
    end

    // Priority scan: lowest slot wins, trap overrides the scan result
    always_comb begin
        win_code = CODE_W'(CODE_RESET);
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (qual[i]) begin
                win_code = CODE_W'(i + SLOT_BASE);
            end
        end
        if (trap_req) begin
            win_code = CODE_W'(CODE_TRAP);
        end
    end

    // Any source pending for the core
    assign any_win = trap_req | (|qual);

endmodule

// File: rtl/irqv_mask_ctl.sv
// Module: global mask bit with a one-deep shadow.
// What it does: sets the mask on entry and saves its old value, and
// restores the saved value on return. Entry wins over a same-cycle return.
// Assumes: handler nesting deeper than one level is not tracked.
module irqv_mask_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic ret,
    output logic gmask,
    output logic shadow
);

    // Mask and shadow update; reset masks and leaves the shadow open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gmask  <= 1'b1;
            shadow <= 1'b0;
        end else if (take) begin
            gmask  <= 1'b1;
            shadow <= gmask;
        end else if (ret) begin
            gmask  <= shadow;
        end
    end

endmodule

// File: rtl/irqv_wake_qual.sv
// Module: wake-up qualifier for low-power states.
// What it does: raises wake when an enabled request of a wake-capable
// slot is present, using a separate capability set per power mode.
// Assumes: the mask bit does not gate wake-up; the trap never wakes.
module irqv_wake_qual
    import irqv_pkg::*;
#(
    parameter int unsigned          NUM_SLOTS  = 14,
    parameter logic [NUM_SLOTS-1:0] HALT_WAKE  = 14'h003C,
    parameter logic [NUM_SLOTS-1:0] AHALT_WAKE = 14'h003E
) (
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic [NUM_SLOTS-1:0] slot_en,
    input  logic [1:0]           pwr_mode,
    output logic                 wake
);

    logic [NUM_SLOTS-1:0] live;
    logic                 halt_hit;
    logic                 ahalt_hit;
    pmode_e               mode;

    // Live requests per slot
    assign live      = slot_req & slot_en;
    assign halt_hit  = |(live & HALT_WAKE);
    assign ahalt_hit = |(live & AHALT_WAKE);
    assign mode      = pmode_e'(pwr_mode);

    // Mode select of the wake capability set
    always_comb begin
        unique case (mode)
            PM_HALT:  wake = halt_hit;
            PM_AHALT: wake = ahalt_hit;
            default:  wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the fixed-priority interrupt vector controller.
// What it does: arbitrates, offers the winner to the core, latches its
// code and vector address on acknowledge, tracks the mask and drives wake.
// Assumes: entry_ack and ret_pulse are single-cycle pulses from the core.
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int unsigned          NUM_SLOTS  = 14,
    parameter int unsigned          ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]    TOP_VEC    = 16'hFFFE,
    parameter logic [NUM_SLOTS-1:0] USED_SLOTS = 14'h0FBE,
    parameter logic [NUM_SLOTS-1:0] HALT_WAKE  = 14'h003C,
    parameter logic [NUM_SLOTS-1:0] AHALT_WAKE = 14'h003E,
    localparam int unsigned         CODE_W     = $clog2(NUM_SLOTS + SLOT_BASE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic [NUM_SLOTS-1:0] slot_en,
    input  logic                 trap_req,
    input  logic                 entry_ack,
    input  logic                 ret_pulse,
    input  logic [1:0]           pwr_mode,
    output logic                 entry_req,
    output logic [ADDR_W-1:0]    vec_addr,
    output logic [CODE_W-1:0]    src_idx,
    output logic                 gmask,
    output logic                 wake
);

    logic              any_win;
    logic [CODE_W-1:0] win_code;
    logic              take;
    logic              shadow;
    logic [ADDR_W-1:0] win_vec;

    irqv_arbiter #(
        .NUM_SLOTS (NUM_SLOTS),
        .CODE_W    (CODE_W),
        .USED_SLOTS(USED_SLOTS)
    ) u_arb (
        .slot_req(slot_req),
        .slot_en (slot_en),
        .trap_req(trap_req),
        .gmask   (gmask),
        .any_win (any_win),
        .win_code(win_code)
    );

    // Accepted entry: acknowledge only counts while a source waits
    assign take      = entry_ack & any_win;
    assign entry_req = any_win;

    irqv_mask_ctl u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .ret   (ret_pulse),
        .gmask (gmask),
        .shadow(shadow)
    );

    irqv_wake_qual #(
        .NUM_SLOTS (NUM_SLOTS),
        .HALT_WAKE (HALT_WAKE),
        .AHALT_WAKE(AHALT_WAKE)
    ) u_wake (
        .slot_req(slot_req),
        .slot_en (slot_en),
        .pwr_mode(pwr_mode),
        .wake    (wake)
    );

    // Two bytes per source, stepping down from the top vector
    assign win_vec = TOP_VEC - ADDR_W'({win_code, 1'b0});

    // Vector and code latch, loaded only by an accepted entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_addr <= TOP_VEC;
            src_idx  <= CODE_W'(CODE_RESET);
        end else if (take) begin
            vec_addr <= win_vec;
            src_idx  <= win_code;
        end
    end

endmodule

// File: rtl/irqv_checker.sv
// Module: property checker for the interrupt vector controller.
// What it does: watches the ports and the mask shadow over time.
// Assumes: bound into every instance of irq_vector_ctrl.
module irqv_checker #(
    parameter int unsigned          NUM_SLOTS  = 14,
    parameter int unsigned          ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]    TOP_VEC    = 16'hFFFE,
    parameter logic [NUM_SLOTS-1:0] USED_SLOTS = 14'h0FBE,
    parameter int unsigned          CODE_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_req,
    input logic              entry_ack,
    input logic              ret_pulse,
    input logic [1:0]        pwr_mode,
    input logic              entry_req,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [CODE_W-1:0] src_idx,
    input logic              gmask,
    input logic              shadow,
    input logic              wake
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (vec_addr == TOP_VEC && src_idx == '0 && gmask));

    assert_unused_absent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx >= CODE_W'(2)) |-> USED_SLOTS[int'(src_idx) - 2]);

    assert_trap_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> entry_req);

    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask && !trap_req) |-> !entry_req);

    assert_entry_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_ack && entry_req) |=> (gmask && shadow == $past(gmask)));

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(entry_ack && entry_req) |=> ($stable(vec_addr) && $stable(src_idx)));

    assert_return_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && !(entry_ack && entry_req)) |=> gmask == $past(shadow));

    assert_idle_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_ack && !entry_req && !ret_pulse) |=> $stable(gmask));

    assert_run_no_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'b00 || pwr_mode == 2'b11) |-> !wake);

endmodule

bind irq_vector_ctrl irqv_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .TOP_VEC   (TOP_VEC),
    .USED_SLOTS(USED_SLOTS),
    .CODE_W    (CODE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_req (trap_req),
    .entry_ack(entry_ack),
    .ret_pulse(ret_pulse),
    .pwr_mode (pwr_mode),
    .entry_req(entry_req),
    .vec_addr (vec_addr),
    .src_idx  (src_idx),
    .gmask    (gmask),
    .shadow   (shadow),
    .wake     (wake)
);

// File: tb/irq_vector_ctrl_bench.sv
// Bench: sweeps single slots, all slot pairs, mixed patterns, masking,
// nesting and every wake combination against an arithmetic model.
module irq_vector_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] slot_req = '0;
    logic [13:0] slot_en = '0;
    logic        trap_req = 1'b0;
    logic        entry_ack = 1'b0;
    logic        ret_pulse = 1'b0;
    logic [1:0]  pwr_mode = 2'b00;
    logic        entry_req;
    logic [15:0] vec_addr;
    logic [3:0]  src_idx;
    logic        gmask;
    logic        wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model state
    logic m_mask;
    logic m_shadow;
    int   m_code;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_req (slot_req),
        .slot_en  (slot_en),
        .trap_req (trap_req),
        .entry_ack(entry_ack),
        .ret_pulse(ret_pulse),
        .pwr_mode (pwr_mode),
        .entry_req(entry_req),
        .vec_addr (vec_addr),
        .src_idx  (src_idx),
        .gmask    (gmask),
        .wake     (wake)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_used(int s);
        return !(s == 0 || s == 6 || s == 12 || s == 13);
    endfunction

    // Expected winner code, -1 when nothing is offered
    function automatic int exp_code(logic [13:0] r, logic [13:0] e, logic t, logic m);
        if (t) return 1;
        if (!m) begin
            for (int s = 0; s < 14; s++) begin
                if (r[s] && e[s] && is_used(s)) return s + 2;
            end
        end
        return -1;
    endfunction

    function automatic int exp_wake(int s, logic en, int mode);
        if (s < 0 || !en) return 0;
        if (mode == 1) return (s >= 2 && s <= 5) ? 1 : 0;
        if (mode == 2) return (s >= 1 && s <= 5) ? 1 : 0;
        return 0;
    endfunction

    task automatic check_latch(string tag);
        chk({tag, " vec_addr"}, int'(vec_addr), 16'hFFFE - 2 * m_code);
        chk({tag, " src_idx"}, int'(src_idx), m_code);
        chk({tag, " gmask"}, int'(gmask), int'(m_mask));
    endtask

    task automatic try_entry(logic [13:0] r, logic [13:0] e, logic t, string tag);
        int c;
        @(negedge clk);
        slot_req = r; slot_en = e; trap_req = t;
        #1;
        c = exp_code(r, e, t, m_mask);
        chk({tag, " entry_req"}, int'(entry_req), (c >= 0) ? 1 : 0);
        entry_ack = 1'b1;
        @(negedge clk);
        entry_ack = 1'b0;
        if (c >= 0) begin
            m_shadow = m_mask;
            m_mask   = 1'b1;
            m_code   = c;
        end
        check_latch(tag);
        slot_req = '0; trap_req = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk);
        ret_pulse = 1'b1;
        @(negedge clk);
        ret_pulse = 1'b0;
        m_mask = m_shadow;
        chk("R7 return gmask", int'(gmask), int'(m_mask));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        slot_req = 14'h3FFF; slot_en = 14'h3FFF; trap_req = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        slot_req = '0; trap_req = 1'b0;
        m_mask = 1'b1; m_shadow = 1'b0; m_code = 0;
        check_latch("R1 reset");
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [13:0] keep;
        do_reset();
        do_ret();

        // R4/R12/R8: every slot alone, enabled and then disabled
        for (int s = 0; s < 14; s++) begin
            try_entry(14'(1) << s, 14'h3FFF, 1'b0, is_used(s) ? "R3 single" : "R4 R8 unused");
            do_ret();
            try_entry(14'(1) << s, ~(14'(1) << s), 1'b0, "R12 disabled");
            do_ret();
        end

        // R2: every pair of slots, trap mixed into some
        for (int i = 0; i < 14; i++) begin
            for (int j = i + 1; j < 14; j++) begin
                try_entry((14'(1) << i) | (14'(1) << j), 14'h3FFF,
                          ((i + j) % 7) == 0, "R2 pair");
                do_ret();
            end
        end

        // R2/R12: mixed request and enable patterns
        lfsr = 16'hACE1;
        for (int k = 0; k < 150; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            try_entry(lfsr[13:0], {lfsr[6:0], lfsr[15:9]}, lfsr[15] & lfsr[3] & lfsr[7], "R2 mixed");
            do_ret();
        end

        // R6: latched result holds while requests change
        try_entry(14'h0008, 14'h3FFF, 1'b0, "R6 entry");
        @(negedge clk);
        slot_req = 14'h3FFF; trap_req = 1'b1;
        repeat (3) @(negedge clk);
        keep = '0;
        slot_req = keep; trap_req = 1'b0;
        chk("R6 hold vec_addr", int'(vec_addr), 16'hFFFE - 2 * 5);
        chk("R6 hold src_idx", int'(src_idx), 5);

        // R8: acknowledge with nothing offered while masked
        @(negedge clk);
        entry_ack = 1'b1;
        @(negedge clk);
        entry_ack = 1'b0;
        check_latch("R8 idle ack");

        // R5: masked slots ignored, trap still offered
        try_entry(14'h3FFF, 14'h3FFF, 1'b0, "R5 masked slots");
        try_entry(14'h0002, 14'h3FFF, 1'b1, "R5 trap while masked");
        do_ret();
        chk("R7 nested stays masked", int'(gmask), 1);

        // R7: entry and return on the same edge, entry wins
        do_reset();
        do_ret();
        @(negedge clk);
        slot_req = 14'h0010; slot_en = 14'h3FFF;
        entry_ack = 1'b1; ret_pulse = 1'b1;
        @(negedge clk);
        entry_ack = 1'b0; ret_pulse = 1'b0; slot_req = '0;
        m_shadow = m_mask; m_mask = 1'b1; m_code = 6;
        check_latch("R7 entry beats return");
        do_ret();

        // R9/R10/R11/R12: wake over every mode, source and enable
        for (int mode = 0; mode < 4; mode++) begin
            for (int s = -1; s < 14; s++) begin
                for (int en = 0; en < 2; en++) begin
                    @(negedge clk);
                    pwr_mode = 2'(mode);
                    trap_req = (s < 0);
                    slot_req = (s < 0) ? 14'h0 : (14'(1) << s);
                    slot_en  = en ? 14'h3FFF : 14'h0;
                    #1;
                    chk(mode == 1 ? "R9 halt wake" : mode == 2 ? "R10 ahalt wake" : "R11 run wake",
                        int'(wake), exp_wake(s, en[0], mode));
                end
            end
        end
        @(negedge clk);
        trap_req = 1'b0; slot_req = '0; pwr_mode = 2'b00;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule